// File: doc/BRIEF.md
# Switched-Beam Complex Weight Applier

This block sits in the transmit path of an antenna array. It takes one user's complex baseband sample stream and produces one weighted complex sample per antenna element. The weights come from an on-chip library holding several weight sets. Each set steers the beam toward one fixed direction. A beam-select input picks the active set. Because the element spacing is fixed, changing the set is the only way the beam direction changes.

The beam-select value is captured together with each accepted input sample. A new selection therefore takes effect at the next sample boundary. Every element switches on the same sample, so an output never mixes two weight sets, and a hand-off between beams needs no flush of the pipeline.

Each element lane is a pipelined complex multiplier. Four real products are registered, then an add/subtract stage follows, with rounding and saturation back to the sample width. Both streams use valid/ready handshaking, and the latency is fixed when there is no backpressure. The library is loaded through a simple write port and can be read back on a separate read port.

Top module: `bfBeamApply`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, and every library entry reads back as I=0, Q=0.
- R2: A write with `wrEn`=1 stores `wrI`/`wrQ` at (`wrBeam`, `wrElem`) on the clock edge. From the next cycle the read port returns that value when addressed with the same beam and element.
- R3: For element e, with input x and weight w of the selected beam, the output I is xI·wI − xQ·wQ and the output Q is xI·wQ + xQ·wI. Both use Q1.15 weights: 2^14 is added and the sum is then shifted arithmetically right by 15 bits, which rounds half up.
- R4: Rounded results above 32767 are output as 32767. Results below −32768 are output as −32768.
- R5: A sample accepted at a clock edge appears with `outValid`=1 after the third following edge, provided `outReady` stays high.
- R6: While `outValid`=1 and `outReady`=0, `inReady` is 0 and `outI`, `outQ` and `outBeam` hold their values. No sample is lost or duplicated.
- R7: `beamSel` is sampled with each accepted sample. All elements of that output use that beam's weights, and `outBeam` reports it. Changing the beam between consecutive samples switches whole samples only.
- R8: A library write made after a sample has been accepted does not change that sample's output.
- R9: Element e occupies bits [16·e+15 : 16·e] of `outI`, `outQ`, and of the library's read order. Element 0 is at the least significant end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block can accept a sample |
| inI | input | 16 | Input sample, in-phase, signed |
| inQ | input | 16 | Input sample, quadrature, signed |
| beamSel | input | 3 | Beam set chosen for this sample |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Downstream accepts output |
| outI | output | 64 | Per-element weighted I, 16 bits each |
| outQ | output | 64 | Per-element weighted Q, 16 bits each |
| outBeam | output | 3 | Beam used for the current output |
| wrEn | input | 1 | Library write strobe |
| wrBeam | input | 3 | Library write beam index |
| wrElem | input | 2 | Library write element index |
| wrI | input | 16 | Weight I to write, signed Q1.15 |
| wrQ | input | 16 | Weight Q to write, signed Q1.15 |
| rdBeam | input | 3 | Library read beam index |
| rdElem | input | 2 | Library read element index |
| rdI | output | 16 | Weight I at the read address |
| rdQ | output | 16 | Weight Q at the read address |

## Verification
The assertions check the following on every cycle: the output hold and input blocking under backpressure, the three-cycle path from an accepted sample to a valid output, the beam tag travelling with that sample, the read-back of a just-written library word, and the state right after reset. The arithmetic of each lane, the saturation corners, the fact that a late library write leaves an in-flight sample alone, and the count of samples through random backpressure can only be shown by the bench. It does this by comparing every output lane against a model of the rounding and clamping.

// File: rtl/bfPkg.sv
package bfPkg;
  // Stage-load strobes sent from control to datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } bfStrobe_t;
endpackage

// File: rtl/bfWeightLib.sv
module bfWeightLib #(
  parameter int NUM_ELEM  = 4,
  parameter int NUM_BEAMS = 8,
  parameter int WGT_W     = 16,
  parameter int BEAM_W    = 3,
  parameter int ELEM_W    = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [BEAM_W-1:0]            wrBeam,
  input  logic [ELEM_W-1:0]            wrElem,
  input  logic [WGT_W-1:0]             wrI,
  input  logic [WGT_W-1:0]             wrQ,
  input  logic [BEAM_W-1:0]            selBeam,
  output logic [NUM_ELEM*WGT_W-1:0]    selWI,
  output logic [NUM_ELEM*WGT_W-1:0]    selWQ,
  input  logic [BEAM_W-1:0]            rdBeam,
  input  logic [ELEM_W-1:0]            rdElem,
  output logic [WGT_W-1:0]             rdI,
  output logic [WGT_W-1:0]             rdQ
);
  logic [WGT_W-1:0] memI [NUM_BEAMS][NUM_ELEM];
  logic [WGT_W-1:0] memQ [NUM_BEAMS][NUM_ELEM];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BEAMS; b++) begin
        for (int e = 0; e < NUM_ELEM; e++) begin
          memI[b][e] <= '0;
          memQ[b][e] <= '0;
        end
      end
    end else if (wrEn) begin
      memI[wrBeam][wrElem] <= wrI;
      memQ[wrBeam][wrElem] <= wrQ;
    end
  end

  // Whole set of the selected beam, element 0 at the low end
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_sel
    assign selWI[e*WGT_W +: WGT_W] = memI[selBeam][e];
    assign selWQ[e*WGT_W +: WGT_W] = memQ[selBeam][e];
  end

  assign rdI = memI[rdBeam][rdElem];
  assign rdQ = memQ[rdBeam][rdElem];
endmodule

// File: rtl/bfCtrl.sv
module bfCtrl
  import bfPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output bfStrobe_t stb
);
  logic v1, v2, v3;
  logic adv;

  // The whole pipe moves together unless the output is blocked
  assign adv      = !v3 || outReady;
  assign inReady  = adv;
  assign outValid = v3;

  always_comb begin
    stb.ld1 = adv && inValid;
    stb.ld2 = adv && v1;
    stb.ld3 = adv && v2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end
endmodule

// File: rtl/bfDatapath.sv
module bfDatapath
  import bfPkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int DATA_W   = 16,
  parameter int WGT_W    = 16,
  parameter int FRAC_W   = 15,
  parameter int BEAM_W   = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bfStrobe_t                    stb,
  input  logic [DATA_W-1:0]            inI,
  input  logic [DATA_W-1:0]            inQ,
  input  logic [BEAM_W-1:0]            inBeam,
  input  logic [NUM_ELEM*WGT_W-1:0]    libWI,
  input  logic [NUM_ELEM*WGT_W-1:0]    libWQ,
  output logic [NUM_ELEM*DATA_W-1:0]   outI,
  output logic [NUM_ELEM*DATA_W-1:0]   outQ,
  output logic [BEAM_W-1:0]            outBeam
);
  localparam int PROD_W = DATA_W + WGT_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] RND_V =
    {{(SUM_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] MAX_V =
    {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V =
    {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] roundSat(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] r;
    r = (v + RND_V) >>> FRAC_W;
    if (r > MAX_V)      roundSat = MAX_V[DATA_W-1:0];
    else if (r < MIN_V) roundSat = MIN_V[DATA_W-1:0];
    else                roundSat = r[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] s1I, s1Q;
  logic [BEAM_W-1:0]        s1Beam, s2Beam, s3Beam;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1I    <= '0;
      s1Q    <= '0;
      s1Beam <= '0;
      s2Beam <= '0;
      s3Beam <= '0;
    end else begin
      if (stb.ld1) begin
        s1I    <= inI;
        s1Q    <= inQ;
        s1Beam <= inBeam;
      end
      if (stb.ld2) s2Beam <= s1Beam;
      if (stb.ld3) s3Beam <= s2Beam;
    end
  end
  assign outBeam = s3Beam;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
    logic signed [WGT_W-1:0]  wI, wQ;
    logic signed [PROD_W-1:0] pII, pQQ, pIQ, pQI;
    logic signed [SUM_W-1:0]  sumI, sumQ;
    logic [DATA_W-1:0]        rI, rQ;

    always_comb begin
      sumI = SUM_W'(pII) - SUM_W'(pQQ);
      sumQ = SUM_W'(pIQ) + SUM_W'(pQI);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wI  <= '0;
        wQ  <= '0;
        pII <= '0;
        pQQ <= '0;
        pIQ <= '0;
        pQI <= '0;
        rI  <= '0;
        rQ  <= '0;
      end else begin
        if (stb.ld1) begin
          wI <= libWI[e*WGT_W +: WGT_W];
          wQ <= libWQ[e*WGT_W +: WGT_W];
        end
        if (stb.ld2) begin
          pII <= PROD_W'(s1I) * PROD_W'(wI);
          pQQ <= PROD_W'(s1Q) * PROD_W'(wQ);
          pIQ <= PROD_W'(s1I) * PROD_W'(wQ);
          pQI <= PROD_W'(s1Q) * PROD_W'(wI);
        end
        if (stb.ld3) begin
          rI <= roundSat(sumI);
          rQ <= roundSat(sumQ);
        end
      end
    end

    assign outI[e*DATA_W +: DATA_W] = rI;
    assign outQ[e*DATA_W +: DATA_W] = rQ;
  end
endmodule

// File: rtl/bfBeamApply.sv
module bfBeamApply
  import bfPkg::*;
#(
  parameter int NUM_ELEM  = 4,
  parameter int NUM_BEAMS = 8,
  parameter int DATA_W    = 16,
  parameter int WGT_W     = 16,
  parameter int FRAC_W    = 15,
  localparam int BEAM_W   = (NUM_BEAMS > 1) ? $clog2(NUM_BEAMS) : 1,
  localparam int ELEM_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [DATA_W-1:0]           inI,
  input  logic [DATA_W-1:0]           inQ,
  input  logic [BEAM_W-1:0]           beamSel,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [NUM_ELEM*DATA_W-1:0]  outI,
  output logic [NUM_ELEM*DATA_W-1:0]  outQ,
  output logic [BEAM_W-1:0]           outBeam,
  input  logic                        wrEn,
  input  logic [BEAM_W-1:0]           wrBeam,
  input  logic [ELEM_W-1:0]           wrElem,
  input  logic [WGT_W-1:0]            wrI,
  input  logic [WGT_W-1:0]            wrQ,
  input  logic [BEAM_W-1:0]           rdBeam,
  input  logic [ELEM_W-1:0]           rdElem,
  output logic [WGT_W-1:0]            rdI,
  output logic [WGT_W-1:0]            rdQ
);
  bfStrobe_t                  stb;
  logic [NUM_ELEM*WGT_W-1:0]  libWI, libWQ;

  bfWeightLib #(
    .NUM_ELEM(NUM_ELEM), .NUM_BEAMS(NUM_BEAMS), .WGT_W(WGT_W),
    .BEAM_W(BEAM_W), .ELEM_W(ELEM_W)
  ) u_lib (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrBeam(wrBeam), .wrElem(wrElem), .wrI(wrI), .wrQ(wrQ),
    .selBeam(beamSel), .selWI(libWI), .selWQ(libWQ),
    .rdBeam(rdBeam), .rdElem(rdElem), .rdI(rdI), .rdQ(rdQ)
  );

  bfCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .stb(stb)
  );

  bfDatapath #(
    .NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .WGT_W(WGT_W),
    .FRAC_W(FRAC_W), .BEAM_W(BEAM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inI(inI), .inQ(inQ), .inBeam(beamSel),
    .libWI(libWI), .libWQ(libWQ),
    .outI(outI), .outQ(outQ), .outBeam(outBeam)
  );
endmodule

// File: rtl/bfBeamApplyChk.sv
module bfBeamApplyChk #(
  parameter int NUM_ELEM = 4,
  parameter int DATA_W   = 16,
  parameter int WGT_W    = 16,
  parameter int BEAM_W   = 3,
  parameter int ELEM_W   = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        inValid,
  input logic                        inReady,
  input logic [BEAM_W-1:0]           beamSel,
  input logic                        outValid,
  input logic                        outReady,
  input logic [NUM_ELEM*DATA_W-1:0]  outI,
  input logic [NUM_ELEM*DATA_W-1:0]  outQ,
  input logic [BEAM_W-1:0]           outBeam,
  input logic                        wrEn,
  input logic [BEAM_W-1:0]           wrBeam,
  input logic [ELEM_W-1:0]           wrElem,
  input logic [WGT_W-1:0]            wrI,
  input logic [WGT_W-1:0]            wrQ,
  input logic [BEAM_W-1:0]           rdBeam,
  input logic [ELEM_W-1:0]           rdElem,
  input logic [WGT_W-1:0]            rdI,
  input logic [WGT_W-1:0]            rdQ
);
  // R1: clean state right out of reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady && rdI == '0 && rdQ == '0));

  // R2: a written word is readable on the next cycle
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (!(rdBeam == $past(wrBeam) && rdElem == $past(wrElem)) ||
              (rdI == $past(wrI) && rdQ == $past(wrQ))));

  // R5: accepted sample is valid at the output three edges later
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 inReady ##1 inReady |=> outValid);

  // R7: the beam tag travels with its sample
  a_r7_beam_tag: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 inReady ##1 inReady |=> (outBeam == $past(beamSel, 3)));

  // R6: blocked output holds and input is refused
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outI) && $stable(outQ) && $stable(outBeam)));

  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

bind bfBeamApply bfBeamApplyChk #(
  .NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .WGT_W(WGT_W),
  .BEAM_W(BEAM_W), .ELEM_W(ELEM_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .beamSel(beamSel), .outValid(outValid), .outReady(outReady),
  .outI(outI), .outQ(outQ), .outBeam(outBeam),
  .wrEn(wrEn), .wrBeam(wrBeam), .wrElem(wrElem), .wrI(wrI), .wrQ(wrQ),
  .rdBeam(rdBeam), .rdElem(rdElem), .rdI(rdI), .rdQ(rdQ)
);

// File: tb/bfBeamApply_tb.sv
module bfBeamApply_tb;
  localparam int NE = 4;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b1, wrEn = 1'b0;
  logic inReady, outValid;
  logic [15:0] inI = '0, inQ = '0, wrI = '0, wrQ = '0, rdI, rdQ;
  logic [2:0]  beamSel = '0, wrBeam = '0, rdBeam = '0, outBeam;
  logic [1:0]  wrElem = '0, rdElem = '0;
  logic [63:0] outI, outQ;

  always #2.5 clk = ~clk;  // 200 MHz

  bfBeamApply u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inI(inI), .inQ(inQ), .beamSel(beamSel), .outValid(outValid),
    .outReady(outReady), .outI(outI), .outQ(outQ), .outBeam(outBeam),
    .wrEn(wrEn), .wrBeam(wrBeam), .wrElem(wrElem), .wrI(wrI), .wrQ(wrQ),
    .rdBeam(rdBeam), .rdElem(rdElem), .rdI(rdI), .rdQ(rdQ)
  );

  typedef struct {
    logic [63:0] eI;
    logic [63:0] eQ;
    int          beam;
    int          req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, sent = 0, got = 0;
  int wI [NB][NE];
  int wQ [NB][NE];
  bit bpMode = 1'b0;

  task automatic check(bit ok, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, expv);
    end
  endtask

  // Reference: round half up at 2^-15, then clamp to 16 bits (R3, R4)
  function automatic logic [15:0] laneRef(longint s);
    longint r;
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  task automatic writeW(int b, int e, int vi, int vq);
    @(negedge clk);
    wrEn = 1'b1; wrBeam = 3'(b); wrElem = 2'(e);
    wrI = 16'(vi); wrQ = 16'(vq);
    @(posedge clk);
    #1 wrEn = 1'b0;
    wI[b][e] = vi; wQ[b][e] = vq;
  endtask

  task automatic readW(int b, int e, int req);
    @(negedge clk);
    rdBeam = 3'(b); rdElem = 2'(e);
    #1;
    check(rdI == 16'(wI[b][e]), $sformatf("R%0d rdI beam %0d elem %0d", req, b, e),
          longint'($signed(rdI)), wI[b][e]);
    check(rdQ == 16'(wQ[b][e]), $sformatf("R%0d rdQ beam %0d elem %0d", req, b, e),
          longint'($signed(rdQ)), wQ[b][e]);
  endtask

  task automatic sendSample(int xi, int xq, int b, int req);
    exp_t x;
    @(negedge clk);
    inValid = 1'b1; inI = 16'(xi); inQ = 16'(xq); beamSel = 3'(b);
    while (!inReady) @(negedge clk);
    for (int e = 0; e < NE; e++) begin
      x.eI[e*16 +: 16] = laneRef(longint'(xi) * wI[b][e] - longint'(xq) * wQ[b][e]);
      x.eQ[e*16 +: 16] = laneRef(longint'(xi) * wQ[b][e] + longint'(xq) * wI[b][e]);
    end
    x.beam = b; x.req = req;
    q.push_back(x);
    sent++;
    @(posedge clk);
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Output ready: always high, or random while backpressure is on
  initial begin
    forever begin
      @(posedge clk);
      #1 outReady = bpMode ? 1'($urandom % 2) : 1'b1;
    end
  end

  // Monitor: pop and compare every handshaked output
  initial begin
    exp_t x;
    forever begin
      @(negedge clk);
      if (rstN && outValid && outReady) begin
        got++;
        if (q.size() == 0) begin
          check(1'b0, "R6 output with nothing outstanding", got, sent);
        end else begin
          x = q.pop_front();
          check(int'(outBeam) == x.beam, $sformatf("R%0d R7 outBeam", x.req),
                outBeam, x.beam);
          for (int e = 0; e < NE; e++) begin
            // lane e sits at bits 16e+15:16e (R9)
            check(outI[e*16 +: 16] == x.eI[e*16 +: 16],
                  $sformatf("R%0d R9 lane %0d I", x.req, e),
                  longint'($signed(outI[e*16 +: 16])), longint'($signed(x.eI[e*16 +: 16])));
            check(outQ[e*16 +: 16] == x.eQ[e*16 +: 16],
                  $sformatf("R%0d R9 lane %0d Q", x.req, e),
                  longint'($signed(outQ[e*16 +: 16])), longint'($signed(x.eQ[e*16 +: 16])));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", got, sent);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++) begin
        wI[b][e] = 0; wQ[b][e] = 0;
      end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    readW(0, 0, 1);
    readW(7, 3, 1);
    readW(3, 2, 1);

    // R2: load the library and read back every word
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++)
        writeW(b, e, b * 4096 + e * 1000 - 14000, e * 3000 - b * 2500 + 500);
    writeW(7, 0, -32768, -32768);
    writeW(7, 1, 32767, 32767);
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++)
        readW(b, e, 2);

    // R5: latency on an empty pipe
    @(negedge clk);
    inValid = 1'b1; inI = 16'(1200); inQ = -16'sd700; beamSel = 3'd1;
    begin
      exp_t x;
      for (int e = 0; e < NE; e++) begin
        x.eI[e*16 +: 16] = laneRef(longint'(1200) * wI[1][e] - longint'(-700) * wQ[1][e]);
        x.eQ[e*16 +: 16] = laneRef(longint'(1200) * wQ[1][e] + longint'(-700) * wI[1][e]);
      end
      x.beam = 1; x.req = 5;
      q.push_back(x);
      sent++;
    end
    @(posedge clk);
    #1 inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R5 outValid one edge after accept", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R5 outValid two edges after accept", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R5 outValid three edges after accept", outValid, 1);
    drain();

    // R3, R7: back-to-back stream, beam changes on every sample
    for (int k = 0; k < 24; k++)
      sendSample(int'($signed(16'($urandom))), int'($signed(16'($urandom))), k % 7, 3);
    sendSample(32767, -32768, 2, 7);
    sendSample(32767, -32768, 5, 7);
    idleIn();
    drain();

    // R4: saturation corners with the extreme beam 7 weights
    sendSample(-32768, 32767, 7, 4);
    sendSample(32767, 32767, 7, 4);
    sendSample(-32768, -32768, 7, 4);
    idleIn();
    drain();

    // R8: a write right after acceptance leaves that sample alone
    sendSample(20000, -15000, 2, 8);
    idleIn();
    writeW(2, 0, 9999, -4321);
    drain();
    readW(2, 0, 2);
    sendSample(20000, -15000, 2, 8);
    idleIn();
    drain();

    // R6: random backpressure, no loss or duplication
    bpMode = 1'b1;
    for (int k = 0; k < 60; k++)
      sendSample(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 int'($urandom % NB), 6);
    idleIn();
    drain();
    bpMode = 1'b0;
    repeat (5) @(negedge clk);
    check(got == sent, "R6 outputs equal inputs", got, sent);
    check(q.size() == 0, "R6 nothing left outstanding", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule